// File: doc/BRIEF.md
# Packed SIMD Integer Multiplier

This block multiplies the packed integer elements of two 64-bit words, lane by lane, and returns one element-width result per lane. Software-visible behaviour is selected by a 32-bit instruction word. Its funct6 field picks one of four products: the low half, the signed high half, the unsigned high half, or the high half of a signed-by-unsigned product. Its funct3 field picks the second operand. That operand is either the matching element of a second vector or the low element bits of a 64-bit scalar, copied into every lane. A separate 2-bit input sets the element width to 8, 16, 32 or 64 bits.

The signed-by-unsigned and signed-by-signed high halves both come from the single unsigned product of the raw lane bits. A correction term is then subtracted from the upper half. Each correction term is the other operand ANDed with a copy of a sign bit spread across the lane. No negation and no branch is involved. Lanes whose mask bit is clear can be made to keep the previous destination value. An instruction that does not decode is flagged and writes nothing. Results are registered and appear one cycle after the request.

Top module: `pmul_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release until the first accepted request, valid_out and illegal_out are 0 and result is all zeros.
- R2: funct6 (insn[31:26]) = 100101 returns, in each lane, the low element-width bits of the product of the two lane operands, at every element width.
- R3: funct6 = 100111 returns, in each lane, the upper element-width bits of the double-width product with both operands taken as two's-complement signed.
- R4: funct6 = 100100 returns, in each lane, the upper element-width bits of the double-width product with both operands taken as unsigned.
- R5: funct6 = 100110 returns, in each lane, the upper half of the product of the opa lane (signed) and the opb lane or scalar (unsigned). The result equals what negating, multiplying and re-negating would give, including the most negative value.
- R6: ew_sel selects the element width: 00 gives 8 bits (8 lanes), 01 gives 16 (4 lanes), 10 gives 32 (2 lanes) and 11 gives 64 (1 lane). Lane i occupies bits [i*W +: W], and no carry or sign crosses a lane boundary.
- R7: funct3 (insn[14:12]) = 010 takes the second operand lane from opb. funct3 = 110 takes it from scalar[W-1:0], replicated into every lane.
- R8: insn[25] = 0 enables masking. Lane i then uses mask[i]: a 0 keeps old_dst[i*W +: W] in that lane, and a 1 writes the product. insn[25] = 1 writes every lane regardless of mask.
- R9: A request whose opcode (insn[6:0]) is not 1010111, or whose funct6 or funct3 is not one of the listed codes, raises illegal_out for one cycle with valid_out low and leaves result unchanged.
- R10: An accepted request raises valid_out exactly one cycle later with the new result. With valid_in low, the next cycle shows valid_out and illegal_out low and result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Request strobe |
| insn | input | 32 | Instruction word: operation, source and mask enable |
| ew_sel | input | 2 | Element width code |
| opa | input | 64 | First packed operand (signed side in R5) |
| opb | input | 64 | Second packed operand |
| scalar | input | 64 | Scalar second operand for vector-scalar requests |
| mask | input | 8 | Per-lane write enables, lane i at bit i |
| old_dst | input | 64 | Prior destination value for masked lanes |
| valid_out | output | 1 | Result valid, one cycle after an accepted request |
| illegal_out | output | 1 | Rejected request flag |
| result | output | 64 | Registered packed result |

## Verification
A wrong sign-correction term affects only high-half results, and only in lanes whose operand has its top bit set. The most negative and all-ones patterns therefore give a wrong byte on the very next valid_out. A broken lane slice or source select misplaces bits at one element width only, so every width is driven with random and corner patterns. A decode or hold fault shows as a stray valid_out, a missing illegal_out, or a result that moves when it should hold, one cycle after the request.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [1:0] {
    MOP_LO    = 2'd0,
    MOP_HI_SS = 2'd1,
    MOP_HI_UU = 2'd2,
    MOP_HI_SU = 2'd3
  } mop_e;

  localparam logic [6:0] OPC_PACKED = 7'b1010111;
  localparam logic [5:0] F6_LO      = 6'b100101;
  localparam logic [5:0] F6_HI_SS   = 6'b100111;
  localparam logic [5:0] F6_HI_UU   = 6'b100100;
  localparam logic [5:0] F6_HI_SU   = 6'b100110;
  localparam logic [2:0] F3_VEC     = 3'b010;
  localparam logic [2:0] F3_SCAL    = 3'b110;

  typedef struct packed {
    logic legal;
    mop_e op;
    logic use_scalar;
    logic mask_en;
  } dec_s;
endpackage

// File: rtl/pmul_decode.sv
module pmul_decode
  import pmul_pkg::*;
(
  input  logic [31:0] insn,
  output dec_s        dec
);
  logic [5:0] f6;
  logic [2:0] f3;
  logic [6:0] opc;
  logic       f6_ok;
  logic       f3_ok;
  logic       unused_fields;

  assign f6  = insn[31:26];
  assign f3  = insn[14:12];
  assign opc = insn[6:0];
  assign unused_fields = ^{insn[24:15], insn[11:7]};

  always_comb begin
    f6_ok  = 1'b1;
    dec.op = MOP_LO;
    case (f6)
      F6_LO:    dec.op = MOP_LO;
      F6_HI_SS: dec.op = MOP_HI_SS;
      F6_HI_UU: dec.op = MOP_HI_UU;
      F6_HI_SU: dec.op = MOP_HI_SU;
      default:  f6_ok  = 1'b0;
    endcase
  end

  assign f3_ok          = (f3 == F3_VEC) || (f3 == F3_SCAL);
  assign dec.use_scalar = (f3 == F3_SCAL);
  assign dec.mask_en    = ~insn[25];
  assign dec.legal      = f6_ok && f3_ok && (opc == OPC_PACKED);
endmodule

// File: rtl/pmul_lane.sv
module pmul_lane
  import pmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  mop_e         op,
  output logic [W-1:0] y
);
  localparam int PW = 2 * W;

  // Spread the sign of s across the lane, then keep u where it is set.
  function automatic logic [W-1:0] sign_gate(input logic [W-1:0] s,
                                             input logic [W-1:0] u);
    return W'($signed(s) >>> (W - 1)) & u;
  endfunction

  logic [PW-1:0] prod_u;
  logic [W-1:0]  hi_u;
  logic [W-1:0]  corr_a;
  logic [W-1:0]  corr_b;

  assign prod_u = PW'(a) * PW'(b);
  assign hi_u   = prod_u[PW-1:W];
  assign corr_a = sign_gate(a, b);
  assign corr_b = sign_gate(b, a);

  always_comb begin
    case (op)
      MOP_LO:    y = prod_u[W-1:0];
      MOP_HI_SS: y = hi_u - corr_a - corr_b;
      MOP_HI_UU: y = hi_u;
      default:   y = hi_u - corr_a;
    endcase
  end
endmodule

// File: rtl/pmul_width_slice.sv
module pmul_width_slice
  import pmul_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int EW     = 8
) (
  input  logic [DATA_W-1:0]    vs2,
  input  logic [DATA_W-1:0]    vs1,
  input  logic [EW-1:0]        scal,
  input  logic                 use_scalar,
  input  mop_e                 op,
  input  logic                 mask_en,
  input  logic [DATA_W/EW-1:0] lane_on,
  input  logic [DATA_W-1:0]    prior,
  output logic [DATA_W-1:0]    y
);
  localparam int LANES = DATA_W / EW;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [EW-1:0] a_i;
    logic [EW-1:0] b_i;
    logic [EW-1:0] p_i;

    assign a_i = vs2[i*EW +: EW];
    assign b_i = use_scalar ? scal : vs1[i*EW +: EW];

    pmul_lane #(.W(EW)) u_lane (
      .a  (a_i),
      .b  (b_i),
      .op (op),
      .y  (p_i)
    );

    assign y[i*EW +: EW] = (mask_en && !lane_on[i]) ? prior[i*EW +: EW] : p_i;
  end
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MIN_EW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid_in,
  input  logic [31:0]              insn,
  input  logic [1:0]               ew_sel,
  input  logic [DATA_W-1:0]        opa,
  input  logic [DATA_W-1:0]        opb,
  input  logic [DATA_W-1:0]        scalar,
  input  logic [DATA_W/MIN_EW-1:0] mask,
  input  logic [DATA_W-1:0]        old_dst,
  output logic                     valid_out,
  output logic                     illegal_out,
  output logic [DATA_W-1:0]        result
);
  localparam int NUM_EW = 4;

  dec_s              dec;
  logic              dec_legal;
  logic              accept;
  logic              reject;
  logic [DATA_W-1:0] y_by_w [NUM_EW];
  logic [DATA_W-1:0] lanes_out;

  pmul_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  assign dec_legal = dec.legal;
  assign accept    = valid_in && dec_legal;
  assign reject    = valid_in && !dec_legal;

  for (genvar k = 0; k < NUM_EW; k++) begin : g_width
    localparam int EW = MIN_EW << k;
    pmul_width_slice #(.DATA_W(DATA_W), .EW(EW)) u_slice (
      .vs2        (opa),
      .vs1        (opb),
      .scal       (scalar[EW-1:0]),
      .use_scalar (dec.use_scalar),
      .op         (dec.op),
      .mask_en    (dec.mask_en),
      .lane_on    (mask[DATA_W/EW-1:0]),
      .prior      (old_dst),
      .y          (y_by_w[k])
    );
  end

  assign lanes_out = y_by_w[ew_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out   <= 1'b0;
      illegal_out <= 1'b0;
      result      <= '0;
    end else begin
      valid_out   <= accept;
      illegal_out <= reject;
      if (accept) result <= lanes_out;
    end
  end
endmodule

// File: rtl/pmul_unit_chk.sv
module pmul_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_in,
  input logic [31:0] insn,
  input logic [1:0]  ew_sel,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic [7:0]  mask,
  input logic [63:0] old_dst,
  input logic        valid_out,
  input logic        illegal_out,
  input logic [63:0] result,
  input logic        dec_legal,
  input logic        accept
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> valid_out);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!valid_out && !illegal_out));

  a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> $stable(result));

  a_r9_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !dec_legal) |=> (illegal_out && !valid_out));

  a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_out |-> $stable(result));

  a_r8_masked_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !insn[25] && !mask[0]) |=> (result[7:0] == $past(old_dst[7:0])));

  a_r2_low_full_width: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && insn[31:26] == 6'b100101 && insn[14:12] == 3'b010 &&
     ew_sel == 2'b11 && (insn[25] || mask[0]))
    |=> (result == $past(opa * opb)));
endmodule

bind pmul_unit pmul_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_in    (valid_in),
  .insn        (insn),
  .ew_sel      (ew_sel),
  .opa         (opa),
  .opb         (opb),
  .mask        (mask),
  .old_dst     (old_dst),
  .valid_out   (valid_out),
  .illegal_out (illegal_out),
  .result      (result),
  .dec_legal   (dec_legal),
  .accept      (accept)
);

// File: tb/pmul_unit_tb.sv
module pmul_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_in;
  logic [31:0] insn;
  logic [1:0]  ew_sel;
  logic [63:0] opa, opb, scalar, old_dst;
  logic [7:0]  mask;
  logic        valid_out, illegal_out;
  logic [63:0] result;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [63:0] exp_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmul_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .insn(insn),
    .ew_sel(ew_sel), .opa(opa), .opb(opb), .scalar(scalar), .mask(mask),
    .old_dst(old_dst), .valid_out(valid_out), .illegal_out(illegal_out),
    .result(result)
  );

  // op: 0 low, 1 signed high, 2 unsigned high, 3 signed-by-unsigned high
  function automatic logic [63:0] lane_ref(input int op, input int w,
                                           input logic [63:0] a, input logic [63:0] b);
    logic [63:0]  m;
    logic [127:0] ea, eb, p;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    ea = {64'd0, a & m};
    eb = {64'd0, b & m};
    if ((op == 1 || op == 3) && a[w-1]) ea = ea | ~{64'd0, m};
    if (op == 1 && b[w-1])              eb = eb | ~{64'd0, m};
    p = ea * eb;
    if (op == 0) return p[63:0] & m;
    return 64'(p >> w) & m;
  endfunction

  function automatic logic [63:0] vec_ref(input int op, input logic [1:0] ew,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] s,
      input bit vx, input bit men, input logic [7:0] m, input logic [63:0] old);
    int w, lanes;
    logic [63:0] r, ai, bi, li, wm;
    w = 8 << ew;
    lanes = 64 / w;
    wm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    r = '0;
    for (int i = 0; i < lanes; i++) begin
      ai = (a >> (i*w)) & wm;
      bi = vx ? (s & wm) : ((b >> (i*w)) & wm);
      li = (men && !m[i]) ? ((old >> (i*w)) & wm) : lane_ref(op, w, ai, bi);
      r = r | (li << (i*w));
    end
    return r;
  endfunction

  function automatic logic [63:0] min_neg(input logic [1:0] ew);
    case (ew)
      2'd0:    return 64'h8080_8080_8080_8080;
      2'd1:    return 64'h8000_8000_8000_8000;
      2'd2:    return 64'h8000_0000_8000_0000;
      default: return 64'h8000_0000_0000_0000;
    endcase
  endfunction

  function automatic logic [63:0] pick(input logic [1:0] ew);
    case ($urandom % 5)
      0:       return '1;
      1:       return min_neg(ew);
      2:       return {$urandom, $urandom} & 64'h0101_0101_0101_0101;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [5:0] f6, input bit vm, input logic [2:0] f3,
      input logic [6:0] opc, input logic [1:0] ew, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] s, input logic [7:0] m,
      input logic [63:0] old, input string tag);
    bit legal;
    int op;
    legal = (opc == 7'b1010111) && (f3 == 3'b010 || f3 == 3'b110) &&
            (f6 == 6'b100101 || f6 == 6'b100111 || f6 == 6'b100100 || f6 == 6'b100110);
    op = (f6 == 6'b100111) ? 1 : (f6 == 6'b100100) ? 2 : (f6 == 6'b100110) ? 3 : 0;
    if (legal) exp_res = vec_ref(op, ew, a, b, s, f3 == 3'b110, !vm, m, old);
    @(negedge clk);
    valid_in = 1'b1;
    insn   = {f6, vm, 5'($urandom), 5'($urandom), f3, 5'($urandom), opc};
    ew_sel = ew; opa = a; opb = b; scalar = s; mask = m; old_dst = old;
    @(negedge clk);
    valid_in = 1'b0;
    check(valid_out == legal && illegal_out == !legal, tag, "flags",
          {62'd0, valid_out, illegal_out}, {62'd0, legal, !legal});
    check(result == exp_res, tag, "result", result, exp_res);
  endtask

  task automatic idle_check;
    @(negedge clk);
    check(!valid_out && !illegal_out && result == exp_res, "R10", "idle hold",
          result, exp_res);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; valid_in = 1'b0; insn = '0; ew_sel = '0;
    opa = '0; opb = '0; scalar = '0; mask = '0; old_dst = '0;
    repeat (3) @(negedge clk);
    check(!valid_out && !illegal_out && result == '0, "R1", "in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!valid_out && !illegal_out && result == '0, "R1", "after reset", result, 64'd0);

    // Directed corners
    run_vec(6'b100101, 1, 3'b010, 7'b1010111, 2'd0, '1, 64'h0202_0202_0202_0202,
            '0, '0, '0, "R6");
    run_vec(6'b100101, 1, 3'b010, 7'b1010111, 2'd2, 64'h1234_5678_9abc_def0,
            64'h0fed_cba9_8765_4321, '0, '0, '0, "R2");
    run_vec(6'b100110, 1, 3'b010, 7'b1010111, 2'd0, min_neg(2'd0), '1, '0, '0, '0, "R5");
    run_vec(6'b100110, 1, 3'b010, 7'b1010111, 2'd3, min_neg(2'd3), '1, '0, '0, '0, "R5");
    run_vec(6'b100111, 1, 3'b010, 7'b1010111, 2'd3, min_neg(2'd3), min_neg(2'd3),
            '0, '0, '0, "R3");
    run_vec(6'b100111, 1, 3'b010, 7'b1010111, 2'd1, '1, min_neg(2'd1), '0, '0, '0, "R3");
    run_vec(6'b100100, 1, 3'b010, 7'b1010111, 2'd3, '1, '1, '0, '0, '0, "R4");
    run_vec(6'b100101, 1, 3'b110, 7'b1010111, 2'd1, 64'h0001_0002_0003_0004, '1,
            64'hffff_ffff_ffff_0005, '0, '0, "R7");
    run_vec(6'b100110, 1, 3'b110, 7'b1010111, 2'd0, min_neg(2'd0), '0,
            64'h0000_0000_0000_00ff, '0, '0, "R7");
    idle_check();
    run_vec(6'b100101, 0, 3'b010, 7'b1010111, 2'd0, '1, '1, '0, 8'b0101_0101,
            64'hdead_beef_cafe_f00d, "R8");
    run_vec(6'b100100, 0, 3'b010, 7'b1010111, 2'd2, '1, '1, '0, 8'b1111_1110,
            64'h1111_2222_3333_4444, "R8");
    run_vec(6'b100100, 1, 3'b010, 7'b1010111, 2'd2, '1, '1, '0, 8'b0000_0000,
            64'h1111_2222_3333_4444, "R8");
    run_vec(6'b100101, 1, 3'b010, 7'b0010111, 2'd0, '1, '1, '0, '0, '0, "R9");
    run_vec(6'b100101, 1, 3'b000, 7'b1010111, 2'd0, '1, '1, '0, '0, '0, "R9");
    run_vec(6'b000000, 1, 3'b010, 7'b1010111, 2'd0, '1, '1, '0, '0, '0, "R9");
    idle_check();

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] f6;
      logic [2:0] f3;
      logic [6:0] opc;
      logic [1:0] ew;
      int sel;
      string tag;
      sel = $urandom % 4;
      f6 = (sel == 0) ? 6'b100101 : (sel == 1) ? 6'b100111 :
           (sel == 2) ? 6'b100100 : 6'b100110;
      tag = (sel == 0) ? "R2" : (sel == 1) ? "R3" : (sel == 2) ? "R4" : "R5";
      f3  = ($urandom % 2) ? 3'b110 : 3'b010;
      opc = 7'b1010111;
      ew  = 2'($urandom);
      if ($urandom % 8 == 0) begin
        tag = "R9";
        case ($urandom % 3)
          0:       opc = 7'($urandom) | 7'b0000001 ^ 7'b1000000;
          1:       f3  = 3'b011;
          default: f6  = 6'b100001;
        endcase
      end
      run_vec(f6, 1'($urandom), f3, opc, ew, pick(ew), pick(ew), pick(ew),
              8'($urandom), {$urandom, $urandom}, tag);
      if ($urandom % 4 == 0) idle_check();
    end

    done = 1;
    report();
    $finish;
  end
endmodule